// File: doc/BRIEF.md
# Mode-Aware Address Decoder

This block sits between a small CPU and the memories and peripheral cores of a security-key SoC. It classifies every 32-bit bus address into a region (boot ROM, main RAM, a scratch RAM reserved for firmware, or one of several cores in the register space) and drives a one-hot select and a write enable toward the addressed target. On the following cycle it returns the target's read word, or a word of its own, together with a one-cycle fault pulse when a write was refused.

The decoder owns a sticky execution-mode flag. After reset the device runs in firmware mode with full access. A write of any value to the mode-switch register moves it to application mode, which lasts until the next reset. In application mode the firmware scratch RAM, the device secret, the device identifier and the memory seed registers disappear from the map. The load-location, load-size, hash-entry and derived-identity registers also become read-only. The device secret is modelled here as an internal stub whose words can each be read once between resets.

Top module: `modal_addr_decoder`

## Requirements
- R1: Bits [31:30] choose the top level (00 ROM, 01 RAM, 10 reserved, 11 register space). ROM answers for 0x0000_0000..0x0000_17ff and RAM for 0x4000_0000..0x4001_ffff. Addresses beyond these ranges are unmapped.
- R2: In the register space, bits [29:24] choose the core: 0x00 entropy source, 0x01 timer, 0x02 device secret, 0x03 serial port, 0x04 touch sensor, 0x10 firmware scratch RAM (2 KiB, offsets below 0x800), 0x3f system control. Any other code is unmapped. The `dev_sel`/`dev_we` bit order is ROM=0, RAM=1, scratch=2, entropy=3, timer=4, serial=5, touch=6, system control=7.
- R3: A request accepted while `cpu_valid` is high is answered by `cpu_ready` on exactly the next cycle. For a granted read, `cpu_rdata` then carries the selected target's word from its slice of `dev_rdata` (bits [32*i+31:32*i] for target i). No `cpu_ready` occurs without a request.
- R4: A read of a reserved or unmapped address returns zero and selects nothing. A write to such an address selects nothing and raises `access_fault` for the response cycle.
- R5: Any write to system-control offset 0x20 (address 0xff00_0020) sets application mode from the next cycle on. Writing it again leaves that mode unchanged and raises no fault. Only reset returns the block to firmware mode.
- R6: A read of address 0xff00_0020 returns 0x0000_0000 in firmware mode and 0xffff_ffff in application mode.
- R7: In application mode the scratch RAM, the secret core, and system-control offsets 0x60..0x6f (device identifier words and the two memory seed words) are invisible. Reads return zero without a select, and writes raise the fault.
- R8: System-control offsets 0x30, 0x34, 0x38 and 0x40..0x5f are writable in firmware mode. In application mode they stay readable, but a write is refused with a fault. Other system-control offsets are open in both modes.
- R9: Secret word k (core 0x02, offset 4k, k below 8) reads as SEED + k*0x0101_0101 the first time after reset, and as zero afterwards. Each word is tracked on its own. A write to a secret word is refused with a fault and does not consume the word. Offsets from 0x20 upward in that core are unmapped.
- R10: A write to ROM is refused with a fault and raises no write enable.
- R11: At most one bit of `dev_sel` is high in any cycle. `dev_we` is high only on the selected bit and only for a granted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; returns to firmware mode and re-arms the secret |
| cpu_valid | input | 1 | Request present this cycle |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_ready | output | 1 | Response cycle for the previous request |
| cpu_rdata | output | 32 | Read word returned with `cpu_ready` |
| access_fault | output | 1 | Previous request was a refused write |
| dev_sel | output | 8 | One-hot target select, same cycle as the request |
| dev_we | output | 8 | Write enable to the selected target |
| dev_rdata | input | 256 | Registered read words of the eight targets, concatenated |
| app_mode | output | 1 | Current execution mode (1 = application) |

## Verification
The mode switch and the gating of the next request can meet on adjacent bus cycles. A write to the switch register is followed with no idle cycle by a write into the scratch RAM and then by a read of the switch register. This shows that the refused write and the all-ones read already see the new mode while the write's own response is still being returned. Secret consumption also coincides with a refused secret write to the same word: the write is placed between two reads of that word, and the bench expects the word's value on the first read and zero on the second.

// File: rtl/mad_pkg.sv
package mad_pkg;

    localparam int DATA_W = 32;
    localparam int NDEV   = 8;

    typedef enum logic [2:0] {
        DEV_ROM   = 3'd0,
        DEV_RAM   = 3'd1,
        DEV_FWRAM = 3'd2,
        DEV_TRNG  = 3'd3,
        DEV_TIMER = 3'd4,
        DEV_UART  = 3'd5,
        DEV_TOUCH = 3'd6,
        DEV_SYS   = 3'd7
    } dev_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_DEV    = 2'd1,
        KIND_MODE   = 2'd2,
        KIND_SECRET = 2'd3
    } kind_e;

    // core codes in address bits [29:24]
    localparam logic [5:0] CORE_TRNG   = 6'h00;
    localparam logic [5:0] CORE_TIMER  = 6'h01;
    localparam logic [5:0] CORE_SECRET = 6'h02;
    localparam logic [5:0] CORE_UART   = 6'h03;
    localparam logic [5:0] CORE_TOUCH  = 6'h04;
    localparam logic [5:0] CORE_FWRAM  = 6'h10;
    localparam logic [5:0] CORE_SYS    = 6'h3f;

    // system-control offsets
    localparam logic [23:0] OFF_MODE      = 24'h20;
    localparam logic [23:0] OFF_LOAD_ADDR = 24'h30;
    localparam logic [23:0] OFF_LOAD_SIZE = 24'h34;
    localparam logic [23:0] OFF_HASH_PTR  = 24'h38;
    localparam logic [23:0] OFF_CDI       = 24'h40;
    localparam logic [23:0] OFF_HID_LO    = 24'h60;
    localparam logic [23:0] OFF_HID_HI    = 24'h70;

    localparam logic [31:0] MODE_ADDR = 32'hff00_0020;

    typedef struct packed {
        kind_e kind;
        dev_e  dev;
        logic  hide_app;
        logic  ro_app;
        logic  ro_always;
    } cls_t;

    typedef struct packed {
        logic              app;
        logic              rsp;
        logic              fault;
        logic              from_dev;
        dev_e              dev;
        logic [DATA_W-1:0] data;
    } st_t;

endpackage

// File: rtl/mad_addr_classify.sv
module mad_addr_classify
    import mad_pkg::*;
#(
    parameter int ROM_BYTES    = 6144,
    parameter int RAM_BYTES    = 131072,
    parameter int FWRAM_BYTES  = 2048,
    parameter int SECRET_WORDS = 8,
    parameter int CDI_WORDS    = 8,
    parameter int IDX_W        = $clog2(SECRET_WORDS)
) (
    input  logic [31:0]      addr,
    output cls_t             cls,
    output logic [IDX_W-1:0] sec_idx
);
    localparam logic [29:0] ROM_LIM = 30'(ROM_BYTES);
    localparam logic [29:0] RAM_LIM = 30'(RAM_BYTES);
    localparam logic [23:0] FW_LIM  = 24'(FWRAM_BYTES);
    localparam logic [23:0] SEC_LIM = 24'(SECRET_WORDS * 4);
    localparam logic [23:0] CDI_END = OFF_CDI + 24'(CDI_WORDS * 4);

    logic [1:0]  top;
    logic [5:0]  core;
    logic [23:0] off;

    assign top     = addr[31:30];
    assign core    = addr[29:24];
    assign off     = addr[23:0];
    assign sec_idx = off[IDX_W+1:2];

    always_comb begin
        cls      = '0;
        cls.kind = KIND_NONE;
        cls.dev  = DEV_ROM;
        case (top)
            2'b00: if (addr[29:0] < ROM_LIM) begin
                cls.kind      = KIND_DEV;
                cls.dev       = DEV_ROM;
                cls.ro_always = 1'b1;
            end
            2'b01: if (addr[29:0] < RAM_LIM) begin
                cls.kind = KIND_DEV;
                cls.dev  = DEV_RAM;
            end
            2'b11: begin
                case (core)
                    CORE_TRNG:  begin cls.kind = KIND_DEV; cls.dev = DEV_TRNG;  end
                    CORE_TIMER: begin cls.kind = KIND_DEV; cls.dev = DEV_TIMER; end
                    CORE_UART:  begin cls.kind = KIND_DEV; cls.dev = DEV_UART;  end
                    CORE_TOUCH: begin cls.kind = KIND_DEV; cls.dev = DEV_TOUCH; end
                    CORE_SECRET: if (off < SEC_LIM) begin
                        cls.kind      = KIND_SECRET;
                        cls.hide_app  = 1'b1;
                        cls.ro_always = 1'b1;
                    end
                    CORE_FWRAM: if (off < FW_LIM) begin
                        cls.kind     = KIND_DEV;
                        cls.dev      = DEV_FWRAM;
                        cls.hide_app = 1'b1;
                    end
                    CORE_SYS: begin
                        cls.dev  = DEV_SYS;
                        cls.kind = (off == OFF_MODE) ? KIND_MODE : KIND_DEV;
                        cls.ro_app = (off == OFF_LOAD_ADDR) || (off == OFF_LOAD_SIZE) ||
                                     (off == OFF_HASH_PTR) ||
                                     ((off >= OFF_CDI) && (off < CDI_END));
                        cls.hide_app = (off >= OFF_HID_LO) && (off < OFF_HID_HI);
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mad_secret_store.sv
module mad_secret_store #(
    parameter int          SECRET_WORDS = 8,
    parameter logic [31:0] SEED         = 32'h5a17_c0de,
    parameter int          IDX_W        = $clog2(SECRET_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word
);
    localparam logic [31:0] STEP = 32'h0101_0101;

    logic [SECRET_WORDS-1:0] used_d, used_q;

    always_comb begin
        used_d = used_q;
        if (take) used_d[idx] = 1'b1;
        word = used_q[idx] ? 32'h0 : (SEED + 32'(idx) * STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

endmodule

// File: rtl/modal_addr_decoder.sv
module modal_addr_decoder
    import mad_pkg::*;
#(
    parameter int          ROM_BYTES    = 6144,
    parameter int          RAM_BYTES    = 131072,
    parameter int          FWRAM_BYTES  = 2048,
    parameter int          SECRET_WORDS = 8,
    parameter int          CDI_WORDS    = 8,
    parameter logic [31:0] SECRET_SEED  = 32'h5a17_c0de
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic                   cpu_we,
    input  logic [31:0]            cpu_addr,
    output logic                   cpu_ready,
    output logic [31:0]            cpu_rdata,
    output logic                   access_fault,
    output logic [7:0]             dev_sel,
    output logic [7:0]             dev_we,
    input  logic [8*DATA_W-1:0]    dev_rdata,
    output logic                   app_mode
);
    localparam int IDX_W = $clog2(SECRET_WORDS);

    cls_t             cls;
    logic [IDX_W-1:0] sec_idx;
    logic [31:0]      sec_word;
    logic             sec_take;
    logic             hidden;
    logic             wr_block;
    st_t              st_d, st_q;

    mad_addr_classify #(
        .ROM_BYTES   (ROM_BYTES),
        .RAM_BYTES   (RAM_BYTES),
        .FWRAM_BYTES (FWRAM_BYTES),
        .SECRET_WORDS(SECRET_WORDS),
        .CDI_WORDS   (CDI_WORDS),
        .IDX_W       (IDX_W)
    ) u_classify (
        .addr   (cpu_addr),
        .cls    (cls),
        .sec_idx(sec_idx)
    );

    mad_secret_store #(
        .SECRET_WORDS(SECRET_WORDS),
        .SEED        (SECRET_SEED),
        .IDX_W       (IDX_W)
    ) u_secret (
        .clk  (clk),
        .rst_n(rst_n),
        .take (sec_take),
        .idx  (sec_idx),
        .word (sec_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rsp      = cpu_valid;
        st_d.fault    = 1'b0;
        st_d.from_dev = 1'b0;
        st_d.dev      = cls.dev;
        st_d.data     = '0;
        dev_sel       = '0;
        dev_we        = '0;
        sec_take      = 1'b0;
        hidden        = st_q.app && cls.hide_app;
        wr_block      = cls.ro_always || (st_q.app && cls.ro_app);

        if (cpu_valid) begin
            case (cls.kind)
                KIND_NONE: st_d.fault = cpu_we;
                KIND_MODE: begin
                    if (cpu_we) st_d.app  = 1'b1;
                    else        st_d.data = st_q.app ? '1 : '0;
                end
                KIND_SECRET: begin
                    if (cpu_we || hidden) begin
                        st_d.fault = cpu_we;
                    end else begin
                        sec_take  = 1'b1;
                        st_d.data = sec_word;
                    end
                end
                default: begin
                    if (hidden) begin
                        st_d.fault = cpu_we;
                    end else if (cpu_we && wr_block) begin
                        st_d.fault = 1'b1;
                    end else begin
                        dev_sel[int'(cls.dev)] = 1'b1;
                        dev_we[int'(cls.dev)]  = cpu_we;
                        st_d.from_dev          = !cpu_we;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.dev <= DEV_ROM;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_ready    = st_q.rsp;
    assign access_fault = st_q.fault;
    assign app_mode     = st_q.app;
    assign cpu_rdata    = st_q.from_dev ? dev_rdata[int'(st_q.dev)*DATA_W +: DATA_W]
                                        : st_q.data;

endmodule

// File: rtl/mad_checker.sv
module mad_checker
    import mad_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_valid,
    input logic        cpu_we,
    input logic [31:0] cpu_addr,
    input logic        cpu_ready,
    input logic [31:0] cpu_rdata,
    input logic        access_fault,
    input logic [7:0]  dev_sel,
    input logic [7:0]  dev_we,
    input logic        app_mode
);
    p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    p_we_within_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we & ~dev_sel) == 8'h00);

    p_ready_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |=> cpu_ready);

    p_no_spurious_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> !cpu_ready);

    p_fault_in_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        access_fault |-> cpu_ready);

    p_mode_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |=> app_mode);

    p_mode_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_we && cpu_addr == MODE_ADDR) |=> app_mode);

    p_mode_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_we && cpu_addr == MODE_ADDR && app_mode)
            |=> cpu_rdata == 32'hffff_ffff);

    p_scratch_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
        app_mode |-> !dev_sel[DEV_FWRAM]);

    p_rom_write_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_we && cpu_addr[31:30] == 2'b00) |=> access_fault);

endmodule

bind modal_addr_decoder mad_checker u_mad_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_valid   (cpu_valid),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_ready   (cpu_ready),
    .cpu_rdata   (cpu_rdata),
    .access_fault(access_fault),
    .dev_sel     (dev_sel),
    .dev_we      (dev_we),
    .app_mode    (app_mode)
);

// File: tb/modal_addr_decoder_tb.sv
module modal_addr_decoder_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] SEED       = 32'h5a17_c0de;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         access_fault;
    logic [7:0]   dev_sel;
    logic [7:0]   dev_we;
    logic [255:0] dev_rdata;
    logic         app_mode;

    int compared = 0;
    int mismatched = 0;

    logic [31:0] q_data[$];
    logic        q_fault[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_src
        assign dev_rdata[i*32 +: 32] = 32'hd0d0_0000 | i;
    end

    modal_addr_decoder #(.SECRET_SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .access_fault(access_fault), .dev_sel(dev_sel), .dev_we(dev_we),
        .dev_rdata(dev_rdata), .app_mode(app_mode)
    );

    function automatic logic [31:0] dv(input int i);
        return 32'hd0d0_0000 | 32'(i);
    endfunction

    function automatic logic [31:0] sec(input int k);
        return SEED + 32'(k) * 32'h0101_0101;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: issue one request, check selects, queue expected response
    task automatic access(input logic we, input logic [31:0] addr,
                          input logic [31:0] exp_d, input logic exp_f,
                          input logic [7:0] exp_sel, input string tag);
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        #1;
        chk(dev_sel == exp_sel, tag, "dev_sel", 32'(dev_sel), 32'(exp_sel));
        chk(dev_we == (we ? exp_sel : 8'h00), tag, "dev_we", 32'(dev_we),
            32'(we ? exp_sel : 8'h00));
        chk($countones(dev_sel) <= 1, "R11", "onehot", 32'(dev_sel), 32'(exp_sel));
        q_data.push_back(we ? 32'h0 : exp_d);
        q_fault.push_back(exp_f);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cpu_valid = 1'b0;
            cpu_we    = 1'b0;
        end
    endtask

    // monitor: compare responses against the scoreboard
    always @(negedge clk) begin
        if (rst_n && cpu_ready) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R3", "unexpected ready", 32'(cpu_ready), 32'h0);
            end else begin
                logic [31:0] d;
                logic        f;
                string       t;
                d = q_data.pop_front();
                f = q_fault.pop_front();
                t = q_tag.pop_front();
                chk(cpu_rdata == d, t, "rdata", cpu_rdata, d);
                chk(access_fault == f, t, "fault", 32'(access_fault), 32'(f));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R3", "reset ready", 32'(cpu_ready), 32'h0);
        chk(app_mode == 1'b0, "R5", "reset mode", 32'(app_mode), 32'h0);
        chk(dev_sel == 8'h00, "R11", "reset sel", 32'(dev_sel), 32'h0);
        rst_n = 1'b1;

        // R1 top-level regions and limits
        access(0, 32'h0000_0000, dv(0), 0, 8'h01, "R1");
        access(0, 32'h0000_17fc, dv(0), 0, 8'h01, "R1");
        access(0, 32'h0000_1800, 0, 0, 8'h00, "R1");
        access(0, 32'h4001_fffc, dv(1), 0, 8'h02, "R1");
        access(0, 32'h4002_0000, 0, 0, 8'h00, "R1");
        access(1, 32'h4000_0100, 0, 0, 8'h02, "R1");
        // R4 reserved and unmapped
        access(0, 32'h8000_0000, 0, 0, 8'h00, "R4");
        access(1, 32'h8000_0000, 0, 1, 8'h00, "R4");
        access(0, 32'hc500_0000, 0, 0, 8'h00, "R4");
        access(1, 32'hd000_0800, 0, 1, 8'h00, "R4");
        idle(2);
        chk(cpu_ready == 1'b0, "R3", "idle ready", 32'(cpu_ready), 32'h0);
        // R2 cores
        access(0, 32'hc000_0010, dv(3), 0, 8'h08, "R2");
        access(0, 32'hc100_0000, dv(4), 0, 8'h10, "R2");
        access(0, 32'hc300_0004, dv(5), 0, 8'h20, "R2");
        access(0, 32'hc400_0000, dv(6), 0, 8'h40, "R2");
        access(0, 32'hd000_07fc, dv(2), 0, 8'h04, "R2");
        access(1, 32'hd000_0000, 0, 0, 8'h04, "R2");
        access(0, 32'hff00_0000, dv(7), 0, 8'h80, "R2");
        // R10 ROM writes
        access(1, 32'h0000_0100, 0, 1, 8'h00, "R10");
        // R9 read-once secret
        access(0, 32'hc200_0000, sec(0), 0, 8'h00, "R9");
        access(0, 32'hc200_0000, 0, 0, 8'h00, "R9");
        access(0, 32'hc200_000c, sec(3), 0, 8'h00, "R9");
        access(1, 32'hc200_0004, 0, 1, 8'h00, "R9");
        access(0, 32'hc200_0004, sec(1), 0, 8'h00, "R9");
        access(1, 32'hc200_0004, 0, 1, 8'h00, "R9");
        access(0, 32'hc200_0004, 0, 0, 8'h00, "R9");
        access(0, 32'hc200_000c, 0, 0, 8'h00, "R9");
        access(0, 32'hc200_0020, 0, 0, 8'h00, "R9");
        // R8 firmware-mode writes allowed
        access(1, 32'hff00_0030, 0, 0, 8'h80, "R8");
        access(1, 32'hff00_0044, 0, 0, 8'h80, "R8");
        // R6 firmware read of switch register; R7 id visible in firmware
        access(0, 32'hff00_0020, 32'h0, 0, 8'h00, "R6");
        access(0, 32'hff00_0060, dv(7), 0, 8'h80, "R7");
        // R5 switch, followed back-to-back by gated accesses
        access(1, 32'hff00_0020, 0, 0, 8'h00, "R5");
        access(1, 32'hd000_0000, 0, 1, 8'h00, "R7");
        chk(app_mode == 1'b1, "R5", "mode after switch", 32'(app_mode), 32'h1);
        access(0, 32'hff00_0020, 32'hffff_ffff, 0, 8'h00, "R6");
        // R7 hidden in application mode
        access(0, 32'hd000_0010, 0, 0, 8'h00, "R7");
        access(0, 32'hc200_0008, 0, 0, 8'h00, "R7");
        access(0, 32'hff00_0060, 0, 0, 8'h00, "R7");
        access(1, 32'hff00_0068, 0, 1, 8'h00, "R7");
        access(1, 32'hc200_0008, 0, 1, 8'h00, "R7");
        // R8 read-only in application mode
        access(0, 32'hff00_0030, dv(7), 0, 8'h80, "R8");
        access(1, 32'hff00_0034, 0, 1, 8'h00, "R8");
        access(1, 32'hff00_0038, 0, 1, 8'h00, "R8");
        access(1, 32'hff00_005c, 0, 1, 8'h00, "R8");
        access(1, 32'hff00_0004, 0, 0, 8'h80, "R8");
        access(1, 32'hc100_0000, 0, 0, 8'h10, "R8");
        // R5 second switch write
        access(1, 32'hff00_0020, 0, 0, 8'h00, "R5");
        idle(3);
        chk(app_mode == 1'b1, "R5", "mode kept", 32'(app_mode), 32'h1);
        chk(q_data.size() == 0, "R3", "pending responses", 32'(q_data.size()), 32'h0);

        // reset returns to firmware mode and re-arms the secret
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(app_mode == 1'b0, "R5", "mode after reset", 32'(app_mode), 32'h0);
        rst_n = 1'b1;
        access(0, 32'hc200_0000, sec(0), 0, 8'h00, "R9");
        access(0, 32'hff00_0020, 32'h0, 0, 8'h00, "R6");
        access(0, 32'hd000_0000, dv(2), 0, 8'h04, "R7");
        idle(3);
        chk(q_data.size() == 0, "R3", "pending responses", 32'(q_data.size()), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule